// File: doc/BRIEF.md
# Dual-Image Reconfiguration Control and Status Registers

This block keeps the control word and the reason record for a two-image upgrade scheme, in which a fixed factory image can hand over to an application image and any fault hands back to the factory image. Logic on a small register bus writes a control word. It holds an image-type flag, a page-aligned start address, a watchdog enable and a watchdog timeout. The same bus reads back the control word and a five-bit reason word.

A core-logic trigger strobe, issued while the factory image is running, emits a one-cycle reconfiguration request. The request carries the programmed start address and the image-type flag. Four fault sources force an immediate fall-back request to the factory image at address zero: a CRC error, an external status line, an external reconfiguration pin and the user watchdog expiring. Each request replaces the reason word with the causes present in that cycle.

Once the image-type flag is 1, the control word can no longer be written and the watchdog runs whatever its enable bit says. Software must then kick the watchdog to stay in the application image.

Top module: `rcfg_regs`

## Requirements
- R1: With `regAddr`=0 the read port shows the control word: bit 0 image flag (1 = application), bits 24:1 start page, bit 25 watchdog enable, bits 37:26 timeout. With `regAddr`=1 it shows the reason word in bits 4:0 with bits 37:5 zero.
- R2: While the image flag is 0, a write with `regAddr`=0 replaces the whole control word, and the new value reads back from the next cycle on.
- R3: While the image flag is 1, control-word writes are ignored.
- R4: After reset the control word and the reason word read zero and `reqValid` is low.
- R5: A trigger strobe in factory mode with the flag at 1 gives a one-cycle `reqValid` in the next cycle, with `reqAddr` = {page, 8'h00} and `reqImage`=1. The reason word becomes 5'b00100, the control word is kept, and the block enters application mode.
- R6: In application mode a trigger strobe is ignored: no request, and the reason word is unchanged.
- R7: A trigger strobe in factory mode with the flag at 0 requests {page, 8'h00} with `reqImage`=0, and then clears the control word.
- R8: A CRC error (reason bit 0), an external status assertion (bit 1) or an external reconfiguration pin (bit 3) requests address 0 with `reqImage`=0 in the next cycle. The reason word is replaced by all causes present in that cycle, the control word clears and the block returns to factory mode.
- R9: The watchdog runs while its enable or the image flag is 1. Without kicks it expires on the (T·2^PRESC_SHIFT+1)-th clock after it starts from zero. Expiry requests address 0 with `reqImage`=0, sets reason bit 4 alone and clears the control word.
- R10: A `wdKick` pulse restarts the watchdog count from zero.
- R11: A trigger strobe that coincides with a fault cause yields the fall-back request (address 0, `reqImage`=0), and the reason word holds both the trigger bit 2 and the fault bit.
- R12: With both the enable and the image flag at 0, the watchdog never expires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 1 | 0 selects control word, 1 selects reason word |
| regWrData | input | 38 | Write data for the control word |
| regRdData | output | 38 | Read data of the selected word |
| trigStrobe | input | 1 | Core-logic reconfiguration trigger |
| crcErrIn | input | 1 | CRC error cause |
| extStatusIn | input | 1 | External status-line assertion cause |
| extConfigIn | input | 1 | External reconfiguration pin cause |
| wdKick | input | 1 | Watchdog restart pulse |
| reqValid | output | 1 | One-cycle reconfiguration request |
| reqAddr | output | 32 | Start address of the requested image |
| reqImage | output | 1 | Requested image type, 1 = application |

## Verification
The hardest state to reach from the ports is an expiring watchdog in application mode, because the control word is locked there and only kicks and faults act on the block. The stimulus first programs a timeout and the flag while still in factory mode, then launches. It kicks at a steady interval shorter than the timeout to show that no request appears. It then stops kicking and counts clocks from the last kick to the fall-back request. A coincident trigger and fault is driven in one cycle to show that the fall-back wins and both reason bits are recorded.

// File: rtl/rcfg_pkg.sv
package rcfg_pkg;
  localparam int STAT_W = 5;
  localparam int ST_CRC  = 0;
  localparam int ST_EXTS = 1;
  localparam int ST_CORE = 2;
  localparam int ST_EXTC = 3;
  localparam int ST_WDOG = 4;

  typedef struct packed {
    logic              wrCtrl;
    logic              clearCtrl;
    logic              launch;
    logic              fallback;
    logic [STAT_W-1:0] cause;
  } rcfgStrobes_t;
endpackage

// File: rtl/rcfg_datapath.sv
module rcfg_datapath
  import rcfg_pkg::*;
#(
  parameter int PAGE_W      = 24,
  parameter int TO_W        = 12,
  parameter int PRESC_SHIFT = 4,
  localparam int CTRL_W     = PAGE_W + TO_W + 2,
  localparam int ADDR_W     = PAGE_W + 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  rcfgStrobes_t      strb,
  input  logic [CTRL_W-1:0] regWrData,
  input  logic              wdKick,
  output logic [CTRL_W-1:0] ctrlWord,
  output logic [STAT_W-1:0] statusWord,
  output logic              imgFlag,
  output logic              wdFire,
  output logic              reqValid,
  output logic [ADDR_W-1:0] reqAddr,
  output logic              reqImage
);
  localparam int CNT_W   = TO_W + PRESC_SHIFT;
  localparam int PAGE_LO = 1;
  localparam int EN_BIT  = PAGE_W + 1;
  localparam int TO_LO   = PAGE_W + 2;

  logic [PAGE_W-1:0] page;
  logic              wdEn;
  logic [TO_W-1:0]   wdTo;
  logic [CNT_W-1:0]  wdCount;
  logic [CNT_W-1:0]  wdLimit;
  logic              wdActive;
  logic              anyEvent;

  assign ctrlWord = {wdTo, wdEn, page, imgFlag};
  assign anyEvent = strb.launch | strb.fallback;

  // control word fields
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      imgFlag <= 1'b0;
      page    <= '0;
      wdEn    <= 1'b0;
      wdTo    <= '0;
    end else if (strb.clearCtrl) begin
      imgFlag <= 1'b0;
      page    <= '0;
      wdEn    <= 1'b0;
      wdTo    <= '0;
    end else if (strb.wrCtrl) begin
      imgFlag <= regWrData[0];
      page    <= regWrData[PAGE_LO +: PAGE_W];
      wdEn    <= regWrData[EN_BIT];
      wdTo    <= regWrData[TO_LO +: TO_W];
    end
  end

  // reason word
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         statusWord <= '0;
    else if (anyEvent) statusWord <= strb.cause;
  end

  // watchdog
  assign wdActive = wdEn | imgFlag;
  assign wdLimit  = CNT_W'(wdTo) << PRESC_SHIFT;
  assign wdFire   = wdActive && (wdCount == wdLimit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                 wdCount <= '0;
    else if (!wdActive || wdKick || anyEvent)  wdCount <= '0;
    else                                       wdCount <= wdCount + 1'b1;
  end

  // request output
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqValid <= 1'b0;
      reqAddr  <= '0;
      reqImage <= 1'b0;
    end else begin
      reqValid <= anyEvent;
      if (strb.fallback) begin
        reqAddr  <= '0;
        reqImage <= 1'b0;
      end else if (strb.launch) begin
        reqAddr  <= {page, 8'h00};
        reqImage <= imgFlag;
      end
    end
  end
endmodule

// File: rtl/rcfg_control.sv
module rcfg_control
  import rcfg_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         regWrEn,
  input  logic         regAddr,
  input  logic         trigStrobe,
  input  logic         crcErrIn,
  input  logic         extStatusIn,
  input  logic         extConfigIn,
  input  logic         imgFlag,
  input  logic         wdFire,
  output rcfgStrobes_t strb,
  output logic         runningApp
);
  logic errAny;
  logic coreHit;

  assign errAny  = crcErrIn | extStatusIn | extConfigIn | wdFire;
  assign coreHit = trigStrobe & ~runningApp;

  always_comb begin
    strb                = '0;
    strb.fallback       = errAny;
    strb.launch         = coreHit & ~errAny;
    strb.cause[ST_CRC]  = crcErrIn;
    strb.cause[ST_EXTS] = extStatusIn;
    strb.cause[ST_CORE] = coreHit;
    strb.cause[ST_EXTC] = extConfigIn;
    strb.cause[ST_WDOG] = wdFire;
    strb.clearCtrl      = errAny | (strb.launch & ~imgFlag);
    strb.wrCtrl         = regWrEn & ~regAddr & ~imgFlag;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              runningApp <= 1'b0;
    else if (errAny)        runningApp <= 1'b0;
    else if (strb.launch)   runningApp <= imgFlag;
  end
endmodule

// File: rtl/rcfg_regs.sv
module rcfg_regs
  import rcfg_pkg::*;
#(
  parameter int PAGE_W      = 24,
  parameter int TO_W        = 12,
  parameter int PRESC_SHIFT = 4,
  localparam int CTRL_W     = PAGE_W + TO_W + 2,
  localparam int ADDR_W     = PAGE_W + 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regAddr,
  input  logic [CTRL_W-1:0] regWrData,
  output logic [CTRL_W-1:0] regRdData,
  input  logic              trigStrobe,
  input  logic              crcErrIn,
  input  logic              extStatusIn,
  input  logic              extConfigIn,
  input  logic              wdKick,
  output logic              reqValid,
  output logic [ADDR_W-1:0] reqAddr,
  output logic              reqImage
);
  rcfgStrobes_t      strb;
  logic [CTRL_W-1:0] ctrlWord;
  logic [STAT_W-1:0] statusWord;
  logic              imgFlag;
  logic              wdFire;
  logic              runningApp;

  rcfg_control u_ctl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .trigStrobe(trigStrobe), .crcErrIn(crcErrIn), .extStatusIn(extStatusIn),
    .extConfigIn(extConfigIn), .imgFlag(imgFlag), .wdFire(wdFire),
    .strb(strb), .runningApp(runningApp)
  );

  rcfg_datapath #(.PAGE_W(PAGE_W), .TO_W(TO_W), .PRESC_SHIFT(PRESC_SHIFT)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .regWrData(regWrData), .wdKick(wdKick),
    .ctrlWord(ctrlWord), .statusWord(statusWord), .imgFlag(imgFlag),
    .wdFire(wdFire), .reqValid(reqValid), .reqAddr(reqAddr), .reqImage(reqImage)
  );

  assign regRdData = regAddr ? CTRL_W'(statusWord) : ctrlWord;
endmodule

// File: rtl/rcfg_checker.sv
module rcfg_checker
  import rcfg_pkg::*;
#(
  parameter int CTRL_W = 38,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              trigStrobe,
  input logic              crcErrIn,
  input logic              extStatusIn,
  input logic              extConfigIn,
  input logic              reqValid,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              reqImage,
  input logic [CTRL_W-1:0] ctrlWord,
  input logic [STAT_W-1:0] statusWord,
  input logic              runningApp,
  input logic              wdFire
);
  logic extFault;
  assign extFault = crcErrIn | extStatusIn | extConfigIn;

  p_locked_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWord[0] && !extFault && !wdFire && !(trigStrobe && !runningApp)) |=> $stable(ctrlWord));

  p_fallback_r8: assert property (@(posedge clk) disable iff (!rstN)
    extFault |=> (reqValid && !reqImage && reqAddr == '0 && ctrlWord == '0 && !runningApp));

  p_reason_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!extFault && !wdFire && !trigStrobe) |=> $stable(statusWord));

  p_launch_r5: assert property (@(posedge clk) disable iff (!rstN)
    (trigStrobe && !runningApp && ctrlWord[0] && !extFault && !wdFire)
      |=> (reqValid && reqImage && runningApp && statusWord == 5'b00100));

  p_app_trigger_ignored_r6: assert property (@(posedge clk) disable iff (!rstN)
    (runningApp && !extFault && !wdFire) |=> !reqValid);

  p_watchdog_reason_r9: assert property (@(posedge clk) disable iff (!rstN)
    (wdFire && !extFault) |=> (statusWord[ST_WDOG] && reqValid && !reqImage));
endmodule

bind rcfg_regs rcfg_checker #(.CTRL_W(CTRL_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .trigStrobe(trigStrobe), .crcErrIn(crcErrIn),
  .extStatusIn(extStatusIn), .extConfigIn(extConfigIn), .reqValid(reqValid),
  .reqAddr(reqAddr), .reqImage(reqImage), .ctrlWord(ctrlWord),
  .statusWord(statusWord), .runningApp(runningApp), .wdFire(wdFire)
);

// File: tb/rcfg_regs_test.sv
`timescale 1ns/1ps
module rcfg_regs_test;
  localparam int CTRL_W = 38;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              regWrEn = 1'b0;
  logic              regAddr = 1'b0;
  logic [CTRL_W-1:0] regWrData = '0;
  logic [CTRL_W-1:0] regRdData;
  logic              trigStrobe = 1'b0;
  logic              crcErrIn = 1'b0;
  logic              extStatusIn = 1'b0;
  logic              extConfigIn = 1'b0;
  logic              wdKick = 1'b0;
  logic              reqValid;
  logic [31:0]       reqAddr;
  logic              reqImage;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  rcfg_regs uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .trigStrobe(trigStrobe),
    .crcErrIn(crcErrIn), .extStatusIn(extStatusIn), .extConfigIn(extConfigIn),
    .wdKick(wdKick), .reqValid(reqValid), .reqAddr(reqAddr), .reqImage(reqImage)
  );

  function automatic logic [CTRL_W-1:0] mkCtrl(logic [11:0] to, logic en,
                                               logic [23:0] pg, logic flag);
    return {to, en, pg, flag};
  endfunction

  localparam logic [CTRL_W-1:0] WR_VEC [4] = '{
    {12'hABC, 1'b1, 24'h123456, 1'b0},
    {12'h001, 1'b0, 24'hFFFFFF, 1'b0},
    {12'h000, 1'b0, 24'h000001, 1'b0},
    {12'hFFF, 1'b1, 24'h800000, 1'b0}
  };

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic writeCtrl(logic [CTRL_W-1:0] d);
    regWrEn = 1'b1; regAddr = 1'b0; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic readWord(logic a, output logic [CTRL_W-1:0] d);
    regAddr = a;
    #0.5;
    d = regRdData;
    regAddr = 1'b0;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual hung expected done");
    finish();
  end

  initial begin
    logic [CTRL_W-1:0] rd;
    int n;
    bit seen;

    repeat (3) @(negedge clk);
    // R4: reset state
    readWord(1'b0, rd); chk("R4 ctrl after reset", 64'(rd), 64'h0);
    readWord(1'b1, rd); chk("R4 reason after reset", 64'(rd), 64'h0);
    chk("R4 reqValid after reset", 64'(reqValid), 64'h0);
    rstN = 1'b1;
    @(negedge clk);

    // R1 / R2: table of writes and readbacks in factory mode
    foreach (WR_VEC[i]) begin
      writeCtrl(WR_VEC[i]);
      readWord(1'b0, rd);
      chk("R2 R1 ctrl readback", 64'(rd), 64'(WR_VEC[i]));
    end
    writeCtrl('0);

    // R12: timeout set but enable and flag clear
    writeCtrl(mkCtrl(12'h001, 1'b0, 24'h0, 1'b0));
    seen = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (reqValid) seen = 1;
    end
    chk("R12 no expiry while disabled", 64'(seen), 64'h0);

    // R9: enabled watchdog, T=1 -> limit 16, expiry on 17th clock
    writeCtrl(mkCtrl(12'h001, 1'b1, 24'h00ABCD, 1'b0));
    n = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      n++;
      if (reqValid) break;
    end
    chk("R9 expiry clock count", 64'(n), 64'd17);
    chk("R9 expiry address", 64'(reqAddr), 64'h0);
    chk("R9 expiry image", 64'(reqImage), 64'h0);
    readWord(1'b1, rd); chk("R9 R1 reason word", 64'(rd), 64'h10);
    readWord(1'b0, rd); chk("R9 ctrl cleared", 64'(rd), 64'h0);
    @(negedge clk);
    chk("R9 request is one cycle", 64'(reqValid), 64'h0);

    // R7: factory trigger with flag 0
    writeCtrl(mkCtrl(12'h000, 1'b0, 24'h00ABCD, 1'b0));
    trigStrobe = 1'b1; @(negedge clk); trigStrobe = 1'b0;
    chk("R7 reqValid", 64'(reqValid), 64'h1);
    chk("R7 address", 64'(reqAddr), 64'h00ABCD00);
    chk("R7 image", 64'(reqImage), 64'h0);
    readWord(1'b1, rd); chk("R7 reason", 64'(rd), 64'h04);
    readWord(1'b0, rd); chk("R7 ctrl cleared", 64'(rd), 64'h0);

    // R3: set flag, then further writes ignored
    writeCtrl(mkCtrl(12'h002, 1'b0, 24'h123456, 1'b1));
    readWord(1'b0, rd); chk("R2 flag write", 64'(rd), 64'(mkCtrl(12'h002, 1'b0, 24'h123456, 1'b1)));
    writeCtrl('0);
    readWord(1'b0, rd); chk("R3 write ignored", 64'(rd), 64'(mkCtrl(12'h002, 1'b0, 24'h123456, 1'b1)));

    // R5: launch application
    trigStrobe = 1'b1; @(negedge clk); trigStrobe = 1'b0;
    chk("R5 reqValid", 64'(reqValid), 64'h1);
    chk("R5 address", 64'(reqAddr), 64'h12345600);
    chk("R5 image", 64'(reqImage), 64'h1);
    readWord(1'b1, rd); chk("R5 reason", 64'(rd), 64'h04);
    readWord(1'b0, rd); chk("R5 ctrl kept", 64'(rd), 64'(mkCtrl(12'h002, 1'b0, 24'h123456, 1'b1)));
    writeCtrl(mkCtrl(12'h000, 1'b0, 24'h0, 1'b0));
    readWord(1'b0, rd); chk("R3 app write ignored", 64'(rd), 64'(mkCtrl(12'h002, 1'b0, 24'h123456, 1'b1)));

    // R6: trigger in application mode ignored
    trigStrobe = 1'b1; @(negedge clk); trigStrobe = 1'b0;
    chk("R6 no request", 64'(reqValid), 64'h0);
    readWord(1'b1, rd); chk("R6 reason unchanged", 64'(rd), 64'h04);

    // R10: kicks keep the forced watchdog (limit 32) quiet
    seen = 0;
    for (int i = 0; i < 100; i++) begin
      wdKick = (i % 20 == 0);
      @(negedge clk);
      if (reqValid) seen = 1;
    end
    wdKick = 1'b0;
    chk("R10 kicked watchdog quiet", 64'(seen), 64'h0);
    wdKick = 1'b1; @(negedge clk); wdKick = 1'b0;
    n = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      n++;
      if (reqValid) break;
    end
    chk("R10 R9 expiry after last kick", 64'(n), 64'd33);
    chk("R9 app expiry image", 64'(reqImage), 64'h0);
    readWord(1'b1, rd); chk("R9 app reason", 64'(rd), 64'h10);
    readWord(1'b0, rd); chk("R9 app ctrl cleared", 64'(rd), 64'h0);

    // R8: two fault causes together
    writeCtrl(mkCtrl(12'h000, 1'b0, 24'h000777, 1'b0));
    crcErrIn = 1'b1; extConfigIn = 1'b1; @(negedge clk);
    crcErrIn = 1'b0; extConfigIn = 1'b0;
    chk("R8 reqValid", 64'(reqValid), 64'h1);
    chk("R8 address", 64'(reqAddr), 64'h0);
    chk("R8 image", 64'(reqImage), 64'h0);
    readWord(1'b1, rd); chk("R8 reason crc+pin", 64'(rd), 64'h09);
    readWord(1'b0, rd); chk("R8 ctrl cleared", 64'(rd), 64'h0);

    // R11: trigger with flag 1 coinciding with external status fault
    writeCtrl(mkCtrl(12'h005, 1'b0, 24'h00BEEF, 1'b1));
    trigStrobe = 1'b1; extStatusIn = 1'b1; @(negedge clk);
    trigStrobe = 1'b0; extStatusIn = 1'b0;
    chk("R11 reqValid", 64'(reqValid), 64'h1);
    chk("R11 address", 64'(reqAddr), 64'h0);
    chk("R11 image", 64'(reqImage), 64'h0);
    readWord(1'b1, rd); chk("R11 reason", 64'(rd), 64'h06);
    writeCtrl(mkCtrl(12'h000, 1'b0, 24'h000042, 1'b0));
    readWord(1'b0, rd); chk("R11 R8 back in factory mode", 64'(rd), 64'(mkCtrl(12'h000, 1'b0, 24'h000042, 1'b0)));

    finish();
  end
endmodule